// File: doc/BRIEF.md
# Code Group Synchronization Receiver

This block is the state machine on the receive side of an 8b/10b serial link that decides whether the link is synchronized to code groups. An upstream decoder sends it three flags for every received symbol: the symbol is the K28.5 comma, the symbol is valid under the current running disparity, and the symbol is invalid. The block watches these flags and holds the link in an initialization phase until it has seen enough consecutive valid commas. It then moves to a data phase.

In the data phase, one invalid symbol puts the machine into a checking phase. There the invalid symbols and the run of consecutive valid symbols are counted. If invalid symbols pile up, the link drops back to initialization and requests resynchronization. If a run of valid symbols arrives first, the link returns to data. The block drives a synchronization request, the active-low form of that request for the transmitter's pin, an in-sync status and the state code. The thresholds are parameters: four commas to lock, four valid symbols to recover, three invalid symbols to lose lock.

Top module: `cgs_rx_sync`

## Requirements
- R1: While reset is active and right after it, the state is INIT, sync_req is 1, sync_n is 0 and in_sync is 0.
- R2: In INIT, a symbol with both sym_comma and sym_valid set adds one to a comma count. Any other symbol (not a comma, or a comma without sym_valid) sets the count back to zero. The fourth consecutive valid comma moves the state to DATA at the clock edge that samples it.
- R3: sync_req is 1 and sync_n is 0 exactly while the state is INIT. in_sync is 1 exactly while the state is DATA or CHECK.
- R4: In DATA, a symbol with sym_invalid set moves the state to CHECK at the next edge. Any other symbol keeps the state in DATA.
- R5: In CHECK, four consecutive symbols that have sym_valid set and sym_invalid clear return the state to DATA. Both counters are cleared on that return.
- R6: In CHECK, an invalid symbol sets the run of valid symbols back to zero, so only consecutive valid symbols count toward recovery.
- R7: The invalid symbol that moves DATA to CHECK counts as the first invalid symbol. The third invalid symbol counted since entering CHECK returns the state to INIT, and valid symbols in between do not reduce that count.
- R8: When sym_valid and sym_invalid are both set, the symbol is treated as invalid. In CHECK, a symbol with neither flag set leaves both counters unchanged.
- R9: The state output uses the codes INIT = 0, DATA = 1, CHECK = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock; one symbol is examined per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_comma | input | 1 | Current symbol is the K28.5 comma |
| sym_valid | input | 1 | Current symbol is valid under the current running disparity |
| sym_invalid | input | 1 | Current symbol is invalid under the current running disparity |
| sync_req | output | 1 | Synchronization request, high in INIT |
| sync_n | output | 1 | Active-low synchronization request for the transmitter |
| in_sync | output | 1 | Code group synchronization held (DATA or CHECK) |
| state | output | 2 | Current state code |

## Verification
The assertions check the following on every cycle:
- Each state transition follows the lock, lose and recover events raised by the counter modules.
- The comma count stays below its limit and clears on any symbol that is not a valid comma.
- The entering invalid symbol loads the invalid count with one.
- An invalid symbol clears the valid run.
- A symbol with neither flag set holds the counters in CHECK.

Only the bench's symbol sequences show that the thresholds are the right ones. These sequences cover:
- a comma run broken one short of lock;
- a valid run broken one short of recovery;
- invalid symbols spread out between valid ones that still reach the loss threshold;
- the priority of invalid when both flags are set.

// File: rtl/cgs_pkg.sv
package cgs_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_DATA  = 2'd1,
    ST_CHECK = 2'd2
  } cgs_state_e;
endpackage

// File: rtl/cgs_comma_counter.sv
module cgs_comma_counter #(
  parameter int unsigned K_LOCK = 4,
  localparam int unsigned KW = $clog2(K_LOCK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed,
  input  logic          good_comma,
  output logic [KW-1:0] kcnt,
  output logic          lock_hit
);
  function automatic logic is_last(input logic [KW-1:0] c);
    return c == KW'(K_LOCK - 1);
  endfunction

  assign lock_hit = armed && good_comma && is_last(kcnt);

  always_ff @(posedge clk) begin
    if (!rst_n)                             kcnt <= '0;
    else if (!armed || !good_comma || lock_hit) kcnt <= '0;
    else                                    kcnt <= kcnt + KW'(1);
  end

  assert_kcnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    kcnt < KW'(K_LOCK));
  assert_kcnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !good_comma) |=> (kcnt == '0));
endmodule

// File: rtl/cgs_err_counters.sv
module cgs_err_counters #(
  parameter int unsigned V_RECOVER = 4,
  parameter int unsigned I_LOSE    = 3,
  localparam int unsigned VW = $clog2(V_RECOVER + 1),
  localparam int unsigned IW = $clog2(I_LOSE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          armed_data,
  input  logic          armed_check,
  input  logic          bad,
  input  logic          good,
  output logic [IW-1:0] icnt,
  output logic [VW-1:0] vcnt,
  output logic          lose_hit,
  output logic          recover_hit
);
  logic good_only;

  function automatic logic i_last(input logic [IW-1:0] c);
    return c == IW'(I_LOSE - 1);
  endfunction
  function automatic logic v_last(input logic [VW-1:0] c);
    return c == VW'(V_RECOVER - 1);
  endfunction

  assign good_only   = good && !bad;
  assign lose_hit    = armed_check && bad && i_last(icnt);
  assign recover_hit = armed_check && good_only && v_last(vcnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt <= '0;
      vcnt <= '0;
    end else if (armed_data) begin
      icnt <= bad ? IW'(1) : '0;
      vcnt <= '0;
    end else if (armed_check) begin
      if (lose_hit || recover_hit) begin
        icnt <= '0;
        vcnt <= '0;
      end else if (bad) begin
        icnt <= icnt + IW'(1);
        vcnt <= '0;
      end else if (good_only) begin
        vcnt <= vcnt + VW'(1);
      end
    end else begin
      icnt <= '0;
      vcnt <= '0;
    end
  end

  assert_first_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_data && bad) |=> (icnt == IW'(1)));
  assert_vrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_check && bad) |=> (vcnt == '0));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_check && !bad && !good) |=> ($stable(icnt) && $stable(vcnt)));
endmodule

// File: rtl/cgs_state_ctl.sv
module cgs_state_ctl
  import cgs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock_hit,
  input  logic       bad,
  input  logic       lose_hit,
  input  logic       recover_hit,
  output cgs_state_e state_q
);
  cgs_state_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_INIT:  if (lock_hit) state_d = ST_DATA;
      ST_DATA:  if (bad)      state_d = ST_CHECK;
      ST_CHECK: begin
        if (lose_hit)         state_d = ST_INIT;
        else if (recover_hit) state_d = ST_DATA;
      end
      default:                state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT && lock_hit) |=> (state_q == ST_DATA));
  assert_stay_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INIT && !lock_hit) |=> (state_q == ST_INIT));
  assert_enter_check_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && bad) |=> (state_q == ST_CHECK));
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA && !bad) |=> (state_q == ST_DATA));
  assert_lose_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lose_hit |=> (state_q == ST_INIT));
  assert_recover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    recover_hit |=> (state_q == ST_DATA));
endmodule

// File: rtl/cgs_rx_sync.sv
module cgs_rx_sync
  import cgs_pkg::*;
#(
  parameter int unsigned K_LOCK    = 4,
  parameter int unsigned V_RECOVER = 4,
  parameter int unsigned I_LOSE    = 3,
  localparam int unsigned KW = $clog2(K_LOCK + 1),
  localparam int unsigned VW = $clog2(V_RECOVER + 1),
  localparam int unsigned IW = $clog2(I_LOSE + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sym_comma,
  input  logic       sym_valid,
  input  logic       sym_invalid,
  output logic       sync_req,
  output logic       sync_n,
  output logic       in_sync,
  output logic [1:0] state
);
  cgs_state_e    state_q;
  logic [KW-1:0] kcnt;
  logic [IW-1:0] icnt;
  logic [VW-1:0] vcnt;
  logic          lock_hit, lose_hit, recover_hit;
  logic          in_init, in_data, in_check;

  assign in_init  = (state_q == ST_INIT);
  assign in_data  = (state_q == ST_DATA);
  assign in_check = (state_q == ST_CHECK);

  cgs_comma_counter #(.K_LOCK(K_LOCK)) u_comma (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (in_init),
    .good_comma (sym_comma && sym_valid),
    .kcnt       (kcnt),
    .lock_hit   (lock_hit)
  );

  cgs_err_counters #(.V_RECOVER(V_RECOVER), .I_LOSE(I_LOSE)) u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed_data  (in_data),
    .armed_check (in_check),
    .bad         (sym_invalid),
    .good        (sym_valid),
    .icnt        (icnt),
    .vcnt        (vcnt),
    .lose_hit    (lose_hit),
    .recover_hit (recover_hit)
  );

  cgs_state_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_hit    (lock_hit),
    .bad         (sym_invalid),
    .lose_hit    (lose_hit),
    .recover_hit (recover_hit),
    .state_q     (state_q)
  );

  assign sync_req = in_init;
  assign sync_n   = ~in_init;
  assign in_sync  = in_data || in_check;
  assign state    = state_q;

  assert_req_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_req) |-> $rose(in_sync));
  assert_init_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_INIT && state_q != ST_INIT) |-> (state_q == ST_DATA));
endmodule

// File: tb/cgs_rx_sync_tb.sv
`timescale 1ns/1ps
module cgs_rx_sync_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_comma = 1'b0, sym_valid = 1'b0, sym_invalid = 1'b0;
  logic       sync_req, sync_n, in_sync;
  logic [1:0] state;
  int         checks = 0;
  int         failures = 0;

  localparam logic [1:0] S_I = 2'd0, S_D = 2'd1, S_C = 2'd2;
  localparam int NV = 34;
  // {comma, valid, invalid, expected state after the edge}
  localparam logic [4:0] VEC [0:NV-1] = '{
    {3'b110, S_I}, {3'b110, S_I}, {3'b110, S_I}, {3'b010, S_I},
    {3'b110, S_I}, {3'b100, S_I}, {3'b110, S_I}, {3'b110, S_I},
    {3'b110, S_I}, {3'b110, S_D}, {3'b010, S_D}, {3'b000, S_D},
    {3'b110, S_D}, {3'b001, S_C}, {3'b010, S_C}, {3'b010, S_C},
    {3'b010, S_C}, {3'b001, S_C}, {3'b010, S_C}, {3'b010, S_C},
    {3'b010, S_C}, {3'b010, S_D}, {3'b001, S_C}, {3'b000, S_C},
    {3'b011, S_C}, {3'b010, S_C}, {3'b001, S_I}, {3'b110, S_I},
    {3'b110, S_I}, {3'b110, S_I}, {3'b110, S_D}, {3'b011, S_C},
    {3'b001, S_C}, {3'b001, S_I}
  };

  cgs_rx_sync u_dut (
    .clk(clk), .rst_n(rst_n), .sym_comma(sym_comma), .sym_valid(sym_valid),
    .sym_invalid(sym_invalid), .sync_req(sync_req), .sync_n(sync_n),
    .in_sync(in_sync), .state(state)
  );

  always #2.5 clk = ~clk;

  task automatic check_outs(input string tag, input logic [1:0] exp_st);
    logic exp_init;
    exp_init = (exp_st == S_I);
    checks++;
    if (state !== exp_st) begin
      failures++;
      $display("FAIL %s state actual=%0d expected=%0d", tag, state, exp_st);
    end
    checks++;
    if (sync_req !== exp_init || sync_n !== !exp_init || in_sync !== !exp_init) begin
      failures++;
      $display("FAIL R3 outputs actual=%b%b%b expected=%b%b%b", sync_req, sync_n,
               in_sync, exp_init, !exp_init, !exp_init);
    end
  endtask

  task automatic drive(input logic [2:0] f);
    @(negedge clk);
    {sym_comma, sym_valid, sym_invalid} = f;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_outs("R1 in reset", S_I);
    rst_n = 1'b1;
    @(negedge clk);
    check_outs("R1 after reset", S_I);

    // Table: covers R2, R4, R5, R6, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      {sym_comma, sym_valid, sym_invalid} = VEC[i][4:2];
      @(negedge clk);
      check_outs($sformatf("R2/R4-R9 vec %0d", i), VEC[i][1:0]);
    end

    // R2: lock only on the edge of the fourth comma
    {sym_comma, sym_valid, sym_invalid} = 3'b110;
    for (int i = 0; i < 3; i++) @(negedge clk);
    check_outs("R2 three commas", S_I);
    @(negedge clk);
    check_outs("R2 fourth comma", S_D);

    // R8: idle symbols in DATA keep DATA
    {sym_comma, sym_valid, sym_invalid} = 3'b000;
    repeat (5) @(negedge clk);
    check_outs("R8 idle data", S_D);

    // R1: reset mid-operation returns to INIT
    drive(3'b001);
    check_outs("R4 enter check", S_C);
    rst_n = 1'b0;
    @(negedge clk);
    check_outs("R1 mid reset", S_I);
    rst_n = 1'b1;
    {sym_comma, sym_valid, sym_invalid} = 3'b110;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check_outs("R2 relock after reset", S_D);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule